// File: doc/BRIEF.md
# Physically Tagged Page Walk Cache

This block is a small, fully associative store of page-table entries placed between a two-dimensional page walker and the memory hierarchy. Every entry is keyed by the system physical address at which the table word lives, so entries read during guest-table steps and nested-table steps share one pool. When the walker presents an address, the block reports in the same cycle whether the 64-bit entry is held and, if so, returns it, which saves a memory access.

On a miss the walker fetches the word from memory and then offers it as a fill. The fill is tagged with its table level and a guest/nested flag. Only non-leaf levels 4, 3 and 2 are kept. Level-1 words are never stored, and that includes the final guest-table read, because the TLB already covers them. Replacement is true least-recently-used across every entry. A flush input empties the whole store in one cycle.

Top module: `ptWalkCache`

## Requirements
- R1: After reset, and after a flush, every lookup misses: `hit` is 0 and `hitData` is 0. `hit` is never 1 while `lookupValid` is 0.
- R2: A lookup whose address matches a valid entry gives `hit`=1 and the stored 64-bit word on `hitData` in the same cycle it is presented, with no clock edge between them.
- R3: `fillLevel` is encoded 0 = level 1, 1 = level 2, 2 = level 3, 3 = level 4. `fillNested` is 1 for a nested-table word and 0 for a guest-table word. A fill with level code 0 is refused in both dimensions and leaves the contents unchanged. A fill with codes 1 to 3 is stored, from either dimension.
- R4: A stored fill whose address is already present overwrites that entry's data in place. No address ever occupies two entries.
- R5: A stored fill of a new address uses the lowest-numbered invalid entry while one exists, and evicts nothing.
- R6: When all entries are valid, a stored fill of a new address replaces the entry whose last use is oldest. A use is a lookup hit or a stored fill, including an overwriting fill.
- R7: An asserted `flush` invalidates every entry at the next clock edge. A fill offered in the same cycle is dropped.
- R8: A lookup in the same cycle as a fill sees the contents from before that fill. The new word is visible from the next cycle.
- R9: When a lookup hit and a stored fill happen in the same cycle, the hit counts as a use before the victim is chosen, so the entry just hit is not evicted. The filled entry then becomes the most recent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| lookupValid | input | 1 | Lookup request present |
| lookupAddr | input | ADDR_W | System physical address to look up |
| hit | output | 1 | Lookup found a valid entry (combinational) |
| hitData | output | DATA_W | Stored entry on a hit, zero otherwise |
| fillValid | input | 1 | Fill offered |
| fillAddr | input | ADDR_W | System physical address of the filled word |
| fillData | input | DATA_W | Page-table word returned by memory |
| fillLevel | input | 2 | Table level code (0 = L1 ... 3 = L4) |
| fillNested | input | 1 | 1 = nested-table word, 0 = guest-table word |

## Verification
Lookup results are combinational, so `hit` and `hitData` are due in the cycle the address is driven. The bench drives inputs on the falling edge and compares one nanosecond later, still before the rising edge. Fills, flushes and recency updates take effect at the next rising edge. The bench reference model therefore advances only after that edge, and each effect is compared on the lookup of the following cycle. A long mixed sweep over a four-entry, eight-address configuration exercises eviction order, overwrites, refused levels and flush collisions against that model.

// File: rtl/ptwcPkg.sv
package ptwcPkg;

  typedef enum logic [1:0] {
    LVL_1 = 2'd0,
    LVL_2 = 2'd1,
    LVL_3 = 2'd2,
    LVL_4 = 2'd3
  } tblLevelE;

  // strobes from control to datapath
  typedef struct packed {
    logic flushAll;
    logic writeEn;
  } ctrlStrobeS;

endpackage

// File: rtl/ptwcDatapath.sv
module ptwcDatapath
  import ptwcPkg::*;
#(
  parameter int ENTRIES = 24,
  parameter int ADDR_W  = 52,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeS         strobe,
  input  logic [IDX_W-1:0]   writeIdx,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic [ADDR_W-1:0]  fillAddr,
  input  logic [DATA_W-1:0]  fillData,
  output logic [ENTRIES-1:0] lookupMatch,
  output logic [ENTRIES-1:0] fillMatch,
  output logic [ENTRIES-1:0] validVec,
  output logic [DATA_W-1:0]  matchData
);

  logic [ENTRIES-1:0][ADDR_W-1:0] tagQ;
  logic [ENTRIES-1:0][DATA_W-1:0] dataQ;
  logic [ENTRIES-1:0]             validQ;

  assign validVec = validQ;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign lookupMatch[e] = validQ[e] && (tagQ[e] == lookupAddr);
    assign fillMatch[e]   = validQ[e] && (tagQ[e] == fillAddr);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
      end else if (strobe.flushAll) begin
        validQ[e] <= 1'b0;
      end else if (strobe.writeEn && writeIdx == IDX_W'(e)) begin
        validQ[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.writeEn && !strobe.flushAll && writeIdx == IDX_W'(e)) begin
        tagQ[e]  <= fillAddr;
        dataQ[e] <= fillData;
      end
    end
  end

  // one entry at most matches, so an OR-reduce mux is enough
  always_comb begin
    matchData = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lookupMatch[e]) matchData = matchData | dataQ[e];
    end
  end

endmodule

// File: rtl/ptwcControl.sv
module ptwcControl
  import ptwcPkg::*;
#(
  parameter int ENTRIES       = 24,
  parameter int GUEST_MIN_LVL = 1,
  parameter int NEST_MIN_LVL  = 1,
  localparam int IDX_W        = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               lookupValid,
  input  logic               fillValid,
  input  logic [1:0]         fillLevel,
  input  logic               fillNested,
  input  logic [ENTRIES-1:0] lookupMatch,
  input  logic [ENTRIES-1:0] fillMatch,
  input  logic [ENTRIES-1:0] validVec,
  output ctrlStrobeS         strobe,
  output logic [IDX_W-1:0]   writeIdx,
  output logic               hit
);

  typedef logic [ENTRIES-1:0][IDX_W-1:0] ageVecT;

  // ageQ holds a permutation: 0 = most recent, ENTRIES-1 = least recent
  ageVecT ageQ;
  ageVecT ageAfterHit;
  ageVecT ageNext;

  function automatic ageVecT touch(input ageVecT ages, input logic [IDX_W-1:0] idx);
    ageVecT res;
    for (int j = 0; j < ENTRIES; j++) begin
      if (IDX_W'(j) == idx) res[j] = '0;
      else if (ages[j] < ages[idx]) res[j] = ages[j] + 1'b1;
      else res[j] = ages[j];
    end
    return res;
  endfunction

  function automatic logic [IDX_W-1:0] encode(input logic [ENTRIES-1:0] oneHot);
    logic [IDX_W-1:0] res;
    res = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (oneHot[j]) res = res | IDX_W'(j);
    end
    return res;
  endfunction

  tblLevelE         lvl;
  logic             levelOk;
  logic             fillOk;
  logic             fillDup;
  logic             freeAny;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] dupIdx;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] lruIdx;

  assign lvl     = tblLevelE'(fillLevel);
  assign levelOk = fillNested ? (int'(lvl) >= NEST_MIN_LVL) : (int'(lvl) >= GUEST_MIN_LVL);
  assign fillOk  = fillValid && levelOk && !flush;
  assign hit     = lookupValid && (|lookupMatch);
  assign hitIdx  = encode(lookupMatch);
  assign dupIdx  = encode(fillMatch);
  assign fillDup = |fillMatch;
  assign freeAny = ~&validVec;

  always_comb begin
    freeIdx = '0;
    for (int j = ENTRIES - 1; j >= 0; j--) begin
      if (!validVec[j]) freeIdx = IDX_W'(j);
    end
  end

  assign ageAfterHit = hit ? touch(ageQ, hitIdx) : ageQ;

  always_comb begin
    lruIdx = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (ageAfterHit[j] == IDX_W'(ENTRIES - 1)) lruIdx = IDX_W'(j);
    end
  end

  always_comb begin
    if (fillDup)      writeIdx = dupIdx;
    else if (freeAny) writeIdx = freeIdx;
    else              writeIdx = lruIdx;
  end

  assign ageNext = fillOk ? touch(ageAfterHit, writeIdx) : ageAfterHit;

  assign strobe.flushAll = flush;
  assign strobe.writeEn  = fillOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < ENTRIES; j++) ageQ[j] <= IDX_W'(j);
    end else begin
      ageQ <= ageNext;
    end
  end

endmodule

// File: rtl/ptWalkCache.sv
module ptWalkCache
  import ptwcPkg::*;
#(
  parameter int ENTRIES       = 24,
  parameter int ADDR_W        = 52,
  parameter int DATA_W        = 64,
  parameter int GUEST_MIN_LVL = 1,
  parameter int NEST_MIN_LVL  = 1,
  localparam int IDX_W        = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hit,
  output logic [DATA_W-1:0] hitData,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  input  logic [1:0]        fillLevel,
  input  logic              fillNested
);

  ctrlStrobeS         strobe;
  logic [IDX_W-1:0]   writeIdx;
  logic [ENTRIES-1:0] lookupMatch;
  logic [ENTRIES-1:0] fillMatch;
  logic [ENTRIES-1:0] validVec;
  logic [DATA_W-1:0]  matchData;

  ptwcControl #(
    .ENTRIES(ENTRIES), .GUEST_MIN_LVL(GUEST_MIN_LVL), .NEST_MIN_LVL(NEST_MIN_LVL)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .flush(flush), .lookupValid(lookupValid),
    .fillValid(fillValid), .fillLevel(fillLevel), .fillNested(fillNested),
    .lookupMatch(lookupMatch), .fillMatch(fillMatch), .validVec(validVec),
    .strobe(strobe), .writeIdx(writeIdx), .hit(hit)
  );

  ptwcDatapath #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .writeIdx(writeIdx),
    .lookupAddr(lookupAddr), .fillAddr(fillAddr), .fillData(fillData),
    .lookupMatch(lookupMatch), .fillMatch(fillMatch), .validVec(validVec),
    .matchData(matchData)
  );

  assign hitData = hit ? matchData : '0;

endmodule

// File: rtl/ptWalkCacheChk.sv
module ptWalkCacheChk #(
  parameter int ENTRIES = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               flush,
  input logic               lookupValid,
  input logic               hit,
  input logic               fillValid,
  input logic [1:0]         fillLevel,
  input logic [ENTRIES-1:0] lookupMatch,
  input logic [ENTRIES-1:0] fillMatch,
  input logic [ENTRIES-1:0] validVec
);

  p_no_dup_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookupMatch) && $onehot0(fillMatch));

  p_hit_needs_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> lookupValid);

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validVec == '0));

  p_leaf_refused_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillLevel == 2'd0 && !flush) |=> (validVec == $past(validVec)));

  p_free_slot_used_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillLevel != 2'd0 && !flush && !(|fillMatch) && !(&validVec))
      |=> ($countones(validVec) == $countones($past(validVec)) + 1));

  p_full_stays_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((&validVec) && !flush) |=> (&validVec));

endmodule

bind ptWalkCache ptWalkCacheChk #(.ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rstN(rstN), .flush(flush), .lookupValid(lookupValid), .hit(hit),
  .fillValid(fillValid), .fillLevel(fillLevel), .lookupMatch(lookupMatch),
  .fillMatch(fillMatch), .validVec(validVec)
);

// File: tb/ptWalkCache_tb_top.sv
`timescale 1ns/1ps
module ptWalkCache_tb_top;

  localparam int N  = 4;
  localparam int AW = 12;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          flush = 1'b0;
  logic          lookupValid = 1'b0;
  logic [AW-1:0] lookupAddr = '0;
  logic          hit;
  logic [DW-1:0] hitData;
  logic          fillValid = 1'b0;
  logic [AW-1:0] fillAddr = '0;
  logic [DW-1:0] fillData = '0;
  logic [1:0]    fillLevel = '0;
  logic          fillNested = 1'b0;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  // reference model: last-use stamps
  bit            mValid [N];
  logic [AW-1:0] mTag   [N];
  logic [DW-1:0] mData  [N];
  int            mStamp [N];
  int            stampNow = 0;

  always #2 clk = ~clk;

  ptWalkCache #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .lookupValid(lookupValid),
    .lookupAddr(lookupAddr), .hit(hit), .hitData(hitData), .fillValid(fillValid),
    .fillAddr(fillAddr), .fillData(fillData), .fillLevel(fillLevel),
    .fillNested(fillNested)
  );

  function automatic int modelFind(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mValid[i] && mTag[i] == a) return i;
    return -1;
  endfunction

  task automatic modelStep(bit lv, logic [AW-1:0] la, bit fv, logic [AW-1:0] fa,
                           logic [DW-1:0] fd, logic [1:0] fl, bit fl_ush);
    int h, t;
    h = modelFind(la);
    if (lv && h >= 0) begin stampNow++; mStamp[h] = stampNow; end
    if (fl_ush) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    end else if (fv && fl != 2'd0) begin
      t = modelFind(fa);
      if (t < 0) for (int i = 0; i < N; i++) if (t < 0 && !mValid[i]) t = i;
      if (t < 0) begin
        t = 0;
        for (int i = 1; i < N; i++) if (mStamp[i] < mStamp[t]) t = i;
      end
      mValid[t] = 1'b1; mTag[t] = fa; mData[t] = fd;
      stampNow++; mStamp[t] = stampNow;
    end
  endtask

  task automatic step(string req, bit lv, logic [AW-1:0] la, bit fv, logic [AW-1:0] fa,
                      logic [DW-1:0] fd, logic [1:0] fl, bit fn, bit fls);
    int h;
    logic expHit;
    logic [DW-1:0] expData;
    @(negedge clk);
    lookupValid = lv; lookupAddr = la; fillValid = fv; fillAddr = fa;
    fillData = fd; fillLevel = fl; fillNested = fn; flush = fls;
    #1;
    h = modelFind(la);
    expHit = lv && (h >= 0);
    expData = expHit ? mData[h] : '0;
    vecCount++;
    if (hit !== expHit || hitData !== expData) begin
      failCount++;
      $display("FAIL %s addr=%h hit=%b exp %b data=%h exp %h", req, la, hit, expHit,
               hitData, expData);
    end
    @(posedge clk);
    modelStep(lv, la, fv, fa, fd, fl, fls);
  endtask

  task automatic look(string req, logic [AW-1:0] a);
    step(req, 1'b1, a, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic fill(string req, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] l, bit n);
    step(req, 1'b0, '0, 1'b1, a, d, l, n, 1'b0);
  endtask

  function automatic logic [DW-1:0] pat(int k);
    return {32'hC0DE0000 + 32'(k), ~32'(k * 7919)};
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin mValid[i] = 1'b0; mStamp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: empty after reset, and idle lookups never hit
    for (int a = 0; a < 8; a++) look("R1", AW'(a));
    step("R1", 1'b0, AW'(3), 1'b0, '0, '0, 2'd0, 1'b0, 1'b0);

    // R3: level-1 refused for both dimensions
    fill("R3", AW'(5), pat(1), 2'd0, 1'b0);
    fill("R3", AW'(6), pat(2), 2'd0, 1'b1);
    look("R3", AW'(5));
    look("R3", AW'(6));

    // R2/R3/R5: levels 2..4 from both dimensions fill the free slots
    fill("R3", AW'(1), pat(10), 2'd1, 1'b0);
    fill("R3", AW'(2), pat(11), 2'd2, 1'b1);
    fill("R5", AW'(3), pat(12), 2'd3, 1'b0);
    fill("R5", AW'(4), pat(13), 2'd1, 1'b1);
    for (int a = 1; a <= 4; a++) look("R2", AW'(a));

    // R4: overwrite in place, capacity unchanged
    fill("R4", AW'(2), pat(20), 2'd2, 1'b0);
    for (int a = 1; a <= 4; a++) look("R4", AW'(a));

    // R6: touch 1, then new fill evicts the oldest use
    look("R6", AW'(1));
    fill("R6", AW'(7), pat(30), 2'd1, 1'b1);
    for (int a = 1; a <= 7; a++) look("R6", AW'(a));

    // R8: lookup same cycle as fill sees old contents, next cycle new
    step("R8", 1'b1, AW'(9), 1'b1, AW'(9), pat(40), 2'd3, 1'b0, 1'b0);
    look("R8", AW'(9));

    // R9: hit on LRU entry in the same cycle as an evicting fill
    fill("R9", AW'(10), pat(41), 2'd1, 1'b0);
    fill("R9", AW'(11), pat(42), 2'd1, 1'b0);
    fill("R9", AW'(12), pat(43), 2'd1, 1'b0);
    step("R9", 1'b1, AW'(9), 1'b1, AW'(13), pat(44), 2'd2, 1'b1, 1'b0);
    for (int a = 9; a <= 13; a++) look("R9", AW'(a));

    // R7: flush wins over same-cycle fill
    step("R7", 1'b1, AW'(13), 1'b1, AW'(14), pat(50), 2'd3, 1'b0, 1'b1);
    for (int a = 9; a <= 14; a++) look("R7", AW'(a));
    fill("R7", AW'(14), pat(51), 2'd1, 1'b0);
    look("R7", AW'(14));

    // R6: mixed sweep over a small address space
    for (int k = 0; k < 4000; k++) begin
      step("R6", 1'($urandom_range(0, 3) != 0), AW'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), AW'($urandom_range(0, 7)), pat(100 + k),
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 60) == 0));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired after %0d vectors", vecCount);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule